// File: doc/BRIEF.md
# Unaligned Instruction Fetch Window Buffer

The block sits between the code cache and the instruction decoders. It keeps two consecutive aligned 16-byte code chunks and cuts a 16-byte fetch window out of them, starting at any byte offset. A window may therefore take its low bytes from the first chunk and its high bytes from the second. Once the decoders accept a window, the buffer works out where the next one begins. If the window ended exactly between two instructions, the next one starts there. Otherwise it starts on the first byte of the instruction that was cut off. A byte marked as the last byte of a predicted-taken jump shortens the window.

When a taken jump is predicted, the control logic sends a redirect. The redirect carries the target address together with three facts about the block that held the jump: its decode-group count, whether it straddles a 16-byte line, and whether the target instruction straddles one. The buffer empties itself and waits for the target chunks. Those three facts decide two things: whether the first new window is snapped down to the 16-byte line or starts exactly on the target, and how many extra cycles it is held back.

Top module: `ifw_buffer`

## Requirements
- R1: After reset `win_valid` is 0 and `chunk_ready` is 1.
- R2: A chunk is taken only when `chunk_valid` and `chunk_ready` are both 1 and `chunk_addr` equals the expected aligned address. The expected address is the aligned redirect target while no chunk is held, and that address plus 16 while one chunk is held. A chunk with any other address is dropped. `chunk_ready` is 0 while two chunks are held.
- R3: `win_valid` is 1 only while both chunks are held and no post-redirect delay remains. Window byte i (bits 8i+7..8i of `win_data`) is the code byte at address `win_addr`+i.
- R4: Suppose a window without a jump end is consumed. If the byte at `win_addr`+16 carries a start mark (bit j of `chunk_starts` marks byte j of its chunk), the next window starts at `win_addr`+16. Otherwise it starts at the highest marked byte among `win_addr`+1 to `win_addr`+15.
- R5: Bit j of `chunk_jend` marks the last byte of a predicted-taken jump. `win_bvalid` bit i is 1 for every window byte up to and including the first marked one, and 0 after it. After consumption, the next window starts on the byte that follows the marked one.
- R6: A valid window that is not consumed and not redirected stays valid, with unchanged address, data and mask.
- R7: Once the next start passes into the second chunk, the first chunk is released. The window stream then continues through any number of sequential chunks.
- R8: In a cycle with `jmp_valid` at 1, `win_valid` is 0. At the next edge both chunks are discarded.
- R9: Extra delay D is counted in cycles in which both chunks are held. It is derived from G = `jmp_groups` (0 or 1 means one group, 2 means two groups, 3 means three or more), BX = `jmp_blk_cross` and TX = `jmp_tgt_cross`. For G=1, D = BX+TX. For G=2, D = BX&TX. For G=3, D = 0. When the cache delivers both target chunks back to back, the first window appears 3+D cycles after the redirect cycle.
- R10: The first window after a redirect starts at the target rounded down to 16 in two cases: G=1 with TX=0, and G=2 with BX=1 and TX=0. In every other case it starts exactly at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chunk_valid | input | 1 | Cache chunk present |
| chunk_addr | input | ADDR_W | Aligned address of the chunk |
| chunk_data | input | 8*CHUNK_BYTES | Chunk bytes, byte 0 in the low bits |
| chunk_starts | input | CHUNK_BYTES | Instruction-start mark per byte |
| chunk_jend | input | CHUNK_BYTES | Taken-jump last-byte mark per byte |
| chunk_ready | output | 1 | Buffer can take a chunk |
| jmp_valid | input | 1 | Taken-jump redirect |
| jmp_target | input | ADDR_W | Jump target address |
| jmp_groups | input | 2 | Decode groups in the jump's block (1, 2, 3 = three or more) |
| jmp_blk_cross | input | 1 | The jump's block straddles a 16-byte line |
| jmp_tgt_cross | input | 1 | The target instruction straddles a 16-byte line |
| win_valid | output | 1 | Window available |
| win_addr | output | ADDR_W | Address of window byte 0 |
| win_data | output | 8*CHUNK_BYTES | Window bytes |
| win_bvalid | output | CHUNK_BYTES | Per-byte valid mask |
| win_consume | input | 1 | Decoders take the window |

## Verification
A wrong chunk offset or a bad next-start choice shows at the next window that is issued. Its `win_addr` would be off, and its bytes would not match the code at that address, so the error is visible one cycle after the consume. A missed chunk release or a wrong address match does not fail at once: the stream stalls, or later windows carry bytes from the wrong line. A delay counter or alignment choice that disagrees with the table moves the cycle of the first post-redirect window, or its address, which can be seen 3 to 6 cycles after the redirect.

// File: rtl/ifw_pkg.sv
package ifw_pkg;

  // Group count encoding: 0 and 1 mean one group, 2 two, 3 three or more.
  function automatic logic [1:0] post_jump_delay(input logic [1:0] groups,
                                                 input logic blk_x,
                                                 input logic tgt_x);
    case (groups)
      2'd2:    return {1'b0, blk_x & tgt_x};
      2'd3:    return 2'd0;
      default: return 2'(blk_x) + 2'(tgt_x);
    endcase
  endfunction

  // 1: first window snapped to the chunk line, 0: starts on the target.
  function automatic logic post_jump_aligned(input logic [1:0] groups,
                                             input logic blk_x,
                                             input logic tgt_x);
    case (groups)
      2'd2:    return blk_x & ~tgt_x;
      2'd3:    return 1'b0;
      default: return ~tgt_x;
    endcase
  endfunction

endpackage

// File: rtl/ifw_store.sv
module ifw_store #(
  parameter int ADDR_W = 32,
  parameter int CB     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [ADDR_W-1:0]   flush_addr,
  input  logic                shift,
  input  logic                chunk_valid,
  input  logic [ADDR_W-1:0]   chunk_addr,
  input  logic [CB*8-1:0]     chunk_data,
  input  logic [CB-1:0]       chunk_starts,
  input  logic [CB-1:0]       chunk_jend,
  output logic                chunk_ready,
  output logic [ADDR_W-1:0]   base,
  output logic                held0,
  output logic                held1,
  output logic [2*CB*8-1:0]   pair_data,
  output logic [2*CB-1:0]     pair_starts,
  output logic [2*CB-1:0]     pair_jend
);
  localparam int BW = CB * 8;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(CB - 1);

  logic [BW-1:0] d0, d1;
  logic [CB-1:0] s0, s1, j0, j1;
  logic [ADDR_W-1:0] want_addr;
  logic take;

  assign chunk_ready = ~(held0 & held1);
  assign want_addr   = held0 ? base + ADDR_W'(CB) : base;
  assign take        = chunk_valid & chunk_ready & ~flush & (chunk_addr == want_addr);

  assign pair_data   = {d1, d0};
  assign pair_starts = {s1, s0};
  assign pair_jend   = {j1, j0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held0 <= 1'b0;
      held1 <= 1'b0;
      base  <= '0;
      d0 <= '0; d1 <= '0; s0 <= '0; s1 <= '0; j0 <= '0; j1 <= '0;
    end else if (flush) begin
      held0 <= 1'b0;
      held1 <= 1'b0;
      base  <= flush_addr & LINE_MASK;
    end else if (shift) begin
      d0 <= d1; s0 <= s1; j0 <= j1;
      held0 <= held1;
      held1 <= 1'b0;
      base  <= base + ADDR_W'(CB);
    end else if (take) begin
      if (!held0) begin
        d0 <= chunk_data; s0 <= chunk_starts; j0 <= chunk_jend;
        held0 <= 1'b1;
      end else begin
        d1 <= chunk_data; s1 <= chunk_starts; j1 <= chunk_jend;
        held1 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifw_window.sv
module ifw_window #(
  parameter int CB = 16,
  localparam int OW = $clog2(CB)
) (
  input  logic [2*CB*8-1:0] pair_data,
  input  logic [2*CB-1:0]   pair_starts,
  input  logic [2*CB-1:0]   pair_jend,
  input  logic [OW-1:0]     off,
  output logic [CB*8-1:0]   win_data,
  output logic [CB-1:0]     win_bvalid,
  output logic [OW:0]       nxt_off
);
  logic          cut;
  logic [OW:0]   cut_pos;
  logic [OW:0]   last_start;
  logic [OW:0]   idx;

  always_comb begin
    cut        = 1'b0;
    cut_pos    = '0;
    last_start = '0;
    idx        = '0;
    win_data   = '0;
    win_bvalid = '0;
    for (int i = 0; i < CB; i++) begin
      idx = {1'b0, off} + (OW+1)'(i);
      win_data[i*8 +: 8] = pair_data[int'(idx)*8 +: 8];
      win_bvalid[i]      = ~cut;
      if (!cut && pair_jend[idx]) begin
        cut     = 1'b1;
        cut_pos = (OW+1)'(i);
      end
      if (i > 0 && pair_starts[idx]) last_start = (OW+1)'(i);
    end
    idx = {1'b0, off} + (OW+1)'(CB);
    if (cut)
      nxt_off = {1'b0, off} + cut_pos + 1'b1;
    else if (pair_starts[idx] || last_start == '0)
      nxt_off = idx;
    else
      nxt_off = {1'b0, off} + last_start;
  end
endmodule

// File: rtl/ifw_ctrl.sv
module ifw_ctrl #(
  parameter int CB = 16,
  localparam int OW = $clog2(CB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir,
  input  logic [OW-1:0] redir_low,
  input  logic [1:0]    redir_groups,
  input  logic          redir_blk_x,
  input  logic          redir_tgt_x,
  input  logic          consume,
  input  logic [OW:0]   nxt_off,
  input  logic          both_held,
  output logic [OW-1:0] off,
  output logic          delay_busy
);
  import ifw_pkg::*;
  logic [1:0] dly;

  assign delay_busy = (dly != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off <= '0;
      dly <= 2'd0;
    end else if (redir) begin
      off <= post_jump_aligned(redir_groups, redir_blk_x, redir_tgt_x) ? '0 : redir_low;
      dly <= post_jump_delay(redir_groups, redir_blk_x, redir_tgt_x);
    end else begin
      if (consume) off <= nxt_off[OW-1:0];
      if (both_held && delay_busy) dly <= dly - 2'd1;
    end
  end
endmodule

// File: rtl/ifw_buffer.sv
module ifw_buffer #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chunk_valid,
  input  logic [ADDR_W-1:0]        chunk_addr,
  input  logic [8*CHUNK_BYTES-1:0] chunk_data,
  input  logic [CHUNK_BYTES-1:0]   chunk_starts,
  input  logic [CHUNK_BYTES-1:0]   chunk_jend,
  output logic                     chunk_ready,
  input  logic                     jmp_valid,
  input  logic [ADDR_W-1:0]        jmp_target,
  input  logic [1:0]               jmp_groups,
  input  logic                     jmp_blk_cross,
  input  logic                     jmp_tgt_cross,
  output logic                     win_valid,
  output logic [ADDR_W-1:0]        win_addr,
  output logic [8*CHUNK_BYTES-1:0] win_data,
  output logic [CHUNK_BYTES-1:0]   win_bvalid,
  input  logic                     win_consume
);
  localparam int OW = $clog2(CHUNK_BYTES);
  localparam int BW = CHUNK_BYTES * 8;

  logic [ADDR_W-1:0]       base;
  logic                    held0, held1;
  logic [2*BW-1:0]         pair_data;
  logic [2*CHUNK_BYTES-1:0] pair_starts, pair_jend;
  logic [OW-1:0]           off;
  logic [OW:0]             nxt_off;
  logic                    delay_busy;

  // Named events
  logic consume_evt;
  logic shift_evt;

  assign win_valid   = held0 & held1 & ~delay_busy & ~jmp_valid;
  assign consume_evt = win_valid & win_consume;
  assign shift_evt   = consume_evt & nxt_off[OW];
  assign win_addr    = base + ADDR_W'(off);

  ifw_store #(.ADDR_W(ADDR_W), .CB(CHUNK_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .flush(jmp_valid), .flush_addr(jmp_target), .shift(shift_evt),
    .chunk_valid(chunk_valid), .chunk_addr(chunk_addr), .chunk_data(chunk_data),
    .chunk_starts(chunk_starts), .chunk_jend(chunk_jend), .chunk_ready(chunk_ready),
    .base(base), .held0(held0), .held1(held1),
    .pair_data(pair_data), .pair_starts(pair_starts), .pair_jend(pair_jend)
  );

  ifw_window #(.CB(CHUNK_BYTES)) u_window (
    .pair_data(pair_data), .pair_starts(pair_starts), .pair_jend(pair_jend),
    .off(off), .win_data(win_data), .win_bvalid(win_bvalid), .nxt_off(nxt_off)
  );

  ifw_ctrl #(.CB(CHUNK_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .redir(jmp_valid), .redir_low(jmp_target[OW-1:0]),
    .redir_groups(jmp_groups), .redir_blk_x(jmp_blk_cross), .redir_tgt_x(jmp_tgt_cross),
    .consume(consume_evt), .nxt_off(nxt_off), .both_held(held0 & held1),
    .off(off), .delay_busy(delay_busy)
  );
endmodule

// File: rtl/ifw_buffer_chk.sv
module ifw_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int CB     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jmp_valid,
  input logic              win_valid,
  input logic              win_consume,
  input logic [ADDR_W-1:0] win_addr,
  input logic [CB*8-1:0]   win_data,
  input logic [CB-1:0]     win_bvalid,
  input logic              consume_evt
);
  assert_flush_hides_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> !win_valid);

  assert_two_chunks_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |=> ##1 !win_valid);

  assert_window_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_consume && !jmp_valid) |=>
      (jmp_valid || (win_valid && $stable(win_addr) && $stable(win_data) && $stable(win_bvalid))));

  assert_advance_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume_evt |=> ((win_addr != $past(win_addr)) &&
                     ((win_addr - $past(win_addr)) <= ADDR_W'(CB))));

  assert_mask_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_bvalid[0] && ((CB'(win_bvalid + 1'b1) & win_bvalid) == '0)));
endmodule

bind ifw_buffer ifw_buffer_chk #(.ADDR_W(ADDR_W), .CB(CHUNK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .win_valid(win_valid),
  .win_consume(win_consume), .win_addr(win_addr), .win_data(win_data),
  .win_bvalid(win_bvalid), .consume_evt(consume_evt)
);

// File: tb/ifw_buffer_test.sv
`timescale 1ns/1ps
module ifw_buffer_test;
  localparam int AW = 32;
  localparam int CB = 16;

  logic clk = 0, rst_n = 0;
  logic chunk_valid = 0;
  logic [AW-1:0] chunk_addr = '0;
  logic [CB*8-1:0] chunk_data = '0;
  logic [CB-1:0] chunk_starts = '0, chunk_jend = '0;
  logic chunk_ready;
  logic jmp_valid = 0;
  logic [AW-1:0] jmp_target = '0;
  logic [1:0] jmp_groups = '0;
  logic jmp_blk_cross = 0, jmp_tgt_cross = 0;
  logic win_valid;
  logic [AW-1:0] win_addr;
  logic [CB*8-1:0] win_data;
  logic [CB-1:0] win_bvalid;
  logic win_consume = 0;

  always #5 clk = ~clk;

  ifw_buffer #(.ADDR_W(AW), .CHUNK_BYTES(CB)) uut (.*);

  int checks = 0, fails = 0;
  int cyc = 0, rcyc = 0;

  typedef struct { logic [AW-1:0] addr; logic [CB-1:0] mask; int lat; int idx; } win_t;
  win_t stage[$];
  win_t sb[$];

  bit st_mem[1024];
  bit je_mem[1024];

  function automatic bit st_at(input logic [AW-1:0] a);
    if (a >= 32'h1000 && a < 32'h1400) return st_mem[int'(a - 32'h1000)];
    return 1'b0;
  endfunction
  function automatic bit je_at(input logic [AW-1:0] a);
    if (a >= 32'h1000 && a < 32'h1400) return je_mem[int'(a - 32'h1000)];
    return 1'b0;
  endfunction
  function automatic logic [7:0] code_byte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Redirect request mailbox (set at negedge, applied by feeder after posedge)
  bit req = 0, req_stale = 0, feed_en = 0;
  logic [AW-1:0] req_t = '0, fa = '0, pend_base = '0;
  logic [1:0] req_g = '0;
  bit req_bx = 0, req_tx = 0;

  // Feeder: cache model and redirect driver
  initial begin
    bit sent_ok, was_redir, stale_now;
    forever begin
      @(negedge clk);
      sent_ok   = chunk_valid && chunk_ready && (chunk_addr == fa);
      was_redir = jmp_valid;
      @(posedge clk); #1;
      stale_now = 0;
      if (was_redir) begin
        fa = pend_base; jmp_valid = 0; feed_en = 1;
        stale_now = req_stale; req_stale = 0;
      end else if (sent_ok) fa = fa + 32'd16;
      if (req) begin
        req = 0;
        jmp_valid = 1; jmp_target = req_t; jmp_groups = req_g;
        jmp_blk_cross = req_bx; jmp_tgt_cross = req_tx;
        pend_base = req_t & ~32'hF;
        rcyc = cyc + 1;
        while (stage.size() > 0) sb.push_back(stage.pop_front());
      end
      chunk_valid = feed_en;
      chunk_addr  = stale_now ? fa + 32'd48 : fa;
      for (int i = 0; i < CB; i++) begin
        chunk_data[i*8 +: 8] = code_byte(chunk_addr + i);
        chunk_starts[i]      = st_at(chunk_addr + i);
        chunk_jend[i]        = je_at(chunk_addr + i);
      end
    end
  end

  // Monitor: scoreboard pop and compare
  initial begin
    win_t it;
    logic [CB*8-1:0] expd;
    forever begin
      @(negedge clk);
      cyc++;
      win_consume = 0;
      if (!rst_n) continue;
      if (jmp_valid) begin
        check(!win_valid, "R8 window hidden during redirect", win_valid, 0);
      end else if (win_valid && sb.size() > 0) begin
        it = sb.pop_front();
        check(win_addr == it.addr, (it.idx == 0) ? "R10 first window address" :
              (it.idx >= 2 ? "R7 stream window address" : "R4 next window address"),
              win_addr, it.addr);
        check(win_bvalid == it.mask, "R5 byte-valid mask", win_bvalid, it.mask);
        expd = '0;
        for (int i = 0; i < CB; i++) if (it.mask[i]) expd[i*8 +: 8] = code_byte(it.addr + i);
        check((win_data & {{8{it.mask[15]}},{8{it.mask[14]}},{8{it.mask[13]}},{8{it.mask[12]}},
                           {8{it.mask[11]}},{8{it.mask[10]}},{8{it.mask[9]}},{8{it.mask[8]}},
                           {8{it.mask[7]}},{8{it.mask[6]}},{8{it.mask[5]}},{8{it.mask[4]}},
                           {8{it.mask[3]}},{8{it.mask[2]}},{8{it.mask[1]}},{8{it.mask[0]}}}) == expd,
              "R3 window bytes", win_data, expd);
        if (it.lat >= 0)
          check((cyc - rcyc) == it.lat, "R9 first window latency (R2 on stale runs)",
                cyc - rcyc, it.lat);
        win_consume = 1;
      end
    end
  end

  // Plan the expected windows of one run, then request the redirect
  task automatic run_jump(input logic [AW-1:0] t, input logic [1:0] g,
                          input bit bx, input bit tx, input int n, input bit stale);
    logic [AW-1:0] p, nx;
    int d, cnt;
    bit dn, found;
    win_t it;
    d  = (g == 2'd3) ? 0 : (g == 2'd2) ? int'(bx && tx) : int'(bx) + int'(tx);
    dn = (g <= 2'd1 && !tx) || (g == 2'd2 && bx && !tx);
    p  = dn ? {t[AW-1:4], 4'h0} : t;
    for (int w = 0; w < n; w++) begin
      found = 0; cnt = CB;
      for (int i = 0; i < CB; i++) if (!found && je_at(p + i)) begin found = 1; cnt = i + 1; end
      if (found) nx = p + cnt;
      else if (st_at(p + 16)) nx = p + 16;
      else begin
        nx = p + 16; found = 0;
        for (int i = CB - 1; i >= 1; i--) if (!found && st_at(p + i)) begin found = 1; nx = p + i; end
      end
      it.addr = p;
      it.mask = (cnt == CB) ? '1 : CB'((1 << cnt) - 1);
      it.lat  = (w == 0) ? 3 + d + int'(stale) : -1;
      it.idx  = w;
      stage.push_back(it);
      p = nx;
    end
    @(negedge clk);
    req_t = t; req_g = g; req_bx = bx; req_tx = tx; req_stale = stale; req = 1;
    while (req || sb.size() > 0) @(negedge clk);
  endtask

  task automatic hold_check();
    logic [AW-1:0] a;
    repeat (4) @(negedge clk);
    a = win_addr;
    check(win_valid, "R6 window present while not consumed", win_valid, 1);
    repeat (3) @(negedge clk);
    check(win_valid && win_addr == a, "R6 window held", win_addr, a);
  endtask

  task automatic run_all();
    int k;
    int pos;
    int lens[10] = '{5, 2, 10, 6, 3, 3, 4, 1, 2, 7};
    pos = 0; k = 0;
    while (pos < 1024) begin st_mem[pos] = 1; pos += lens[k % 10]; k++; end
    je_mem[32'h1D5] = 1;

    repeat (3) @(negedge clk);
    check(win_valid == 0, "R1 reset win_valid", win_valid, 0);
    check(chunk_ready == 1, "R1 reset chunk_ready", chunk_ready, 1);
    rst_n = 1;

    k = 0;
    for (int g = 1; g <= 3; g++)
      for (int c = 0; c < 4; c++) begin
        run_jump(32'h1010 + 32'h20 * k + ((k * 5) % 16), 2'(g), c[1], c[0], 3, 0);
        hold_check();
        k++;
      end
    // G encoded as 0 behaves as one group
    run_jump(32'h1107, 2'd0, 0, 1, 3, 0);
    // R2: a chunk with a wrong address is dropped
    run_jump(32'h1045, 2'd1, 1, 1, 3, 1);
    // R5: jump end inside the window
    run_jump(32'h11D0, 2'd3, 0, 0, 3, 0);
    // R7: long sequential stream
    run_jump(32'h1003, 2'd3, 1, 1, 12, 0);
    hold_check();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule